// File: doc/BRIEF.md
# Zero-Default APB Word Memory

This block is an APB completer that stores 32-bit words in a small internal array. A requester writes and reads words through the standard APB setup and access phases. Every transfer finishes in exactly two cycles: there are no wait states, no ready signal and no error response. The block decodes a 4 KB window at the bottom of the address space, one word per aligned address.

Each word has a written flag next to it. Reset clears every flag in a single step. A location that has not been written since the last reset therefore reads back as zero, and no stale data can be seen.

Read data is registered at the end of the setup cycle, so it is already stable on `prdata` through the whole access cycle. A read issued directly after a write to the same word, with no idle cycle between them, returns the new value. This holds because the write commits at the end of its access cycle, and the next setup edge looks up the array after that.

Top module: `apb_zero_mem`

## Requirements
- R1: A transfer starts only in a setup cycle (psel=1, penable=0). The pwrite value in that cycle selects the direction. A write commits pwdata to the word named by paddr in the access cycle that follows, and only at the end of that access cycle.
- R2: For a read, the addressed word appears on prdata at the clock edge that ends the setup cycle, and stays stable through the access cycle.
- R3: A read of a word that has not been written since reset returns zero.
- R4: While rstN is low, prdata is zero. After reset every word reads as zero, including words written before the reset.
- R5: A transfer whose address bits 31:12 are not all zero is outside the window. Such a write changes no word, even the word its low bits alias. Such a read returns zero.
- R6: A read setup in the cycle right after a write's access cycle, to the same word, returns the value just written.
- R7: A cycle with psel=0, or an access cycle that does not follow a setup cycle, changes no word. prdata keeps its value in every cycle other than a read setup.
- R8: Address bits 11:2 select one of 1024 words, and bits 1:0 are not decoded. Different words are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Select for this completer |
| penable | input | 1 | High in the access cycle of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read; sampled in the setup cycle |
| paddr | input | 32 | Byte address |
| pwdata | input | 32 | Write data, taken in the access cycle |
| prdata | output | 32 | Read data, registered at the end of the setup cycle |

## Verification
The assertions check four things on every cycle:
- prdata holds outside read setups.
- prdata is zero during reset.
- An out-of-window read setup yields zero.
- A read immediately after a write returns the written word.

Only the bench's scenarios show the stored contents:
- the table of writes and reads checks data retention, word independence, the aliasing of bits 1:0 and that an out-of-window write leaves its alias untouched;
- directed tests check that an access cycle with no setup before it stores nothing;
- directed tests check that a reset in mid-run erases earlier writes.

// File: rtl/apb_zero_mem_pkg.sv
package apb_zero_mem_pkg;

  // Strobes passed from control to datapath, one set per cycle
  typedef struct packed {
    logic wrEn;      // commit pwdata to the addressed word this edge
    logic rdLoad;    // load prdata from the addressed word this edge
    logic inWindow;  // address upper bits are all zero
  } memStrobe_t;

  // What the previous cycle announced as a setup
  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_WRITE = 2'd1,
    PEND_READ  = 2'd2
  } pendKind_t;

endpackage

// File: rtl/apb_zero_mem_ctrl.sv
module apb_zero_mem_ctrl
  import apb_zero_mem_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [ADDR_W-1:WIN_BITS] addrHigh,
  output memStrobe_t               strobe
);

  pendKind_t pendKind;
  logic      setupCycle;
  logic      accessCycle;

  assign setupCycle  = psel && !penable;
  assign accessCycle = psel && penable;

  // Remember what the setup cycle asked for; any other cycle clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendKind <= PEND_NONE;
    end else if (setupCycle) begin
      pendKind <= pwrite ? PEND_WRITE : PEND_READ;
    end else begin
      pendKind <= PEND_NONE;
    end
  end

  always_comb begin
    strobe.inWindow = (addrHigh == '0);
    strobe.wrEn     = accessCycle && (pendKind == PEND_WRITE) && strobe.inWindow;
    strobe.rdLoad   = setupCycle && !pwrite;
  end

endmodule

// File: rtl/apb_zero_mem_dp.sv
module apb_zero_mem_dp
  import apb_zero_mem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  written;
  logic [DATA_W-1:0] lookup;

  // Storage itself needs no reset: the written flags mask it
  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      store[wordIdx] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      written <= '0;
    end else if (strobe.wrEn) begin
      written[wordIdx] <= 1'b1;
    end
  end

  always_comb begin
    lookup = (strobe.inWindow && written[wordIdx]) ? store[wordIdx] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdLoad) begin
      rdData <= lookup;
    end
  end

endmodule

// File: rtl/apb_zero_mem.sv
module apb_zero_mem
  import apb_zero_mem_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 12,
  localparam int BYTE_OFF = $clog2(DATA_W / 8),
  localparam int IDX_W    = WIN_BITS - BYTE_OFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata
);

  memStrobe_t strobe;

  apb_zero_mem_ctrl #(
    .ADDR_W  (ADDR_W),
    .WIN_BITS(WIN_BITS)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .addrHigh(paddr[ADDR_W-1:WIN_BITS]),
    .strobe  (strobe)
  );

  apb_zero_mem_dp #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wordIdx(paddr[WIN_BITS-1:BYTE_OFF]),
    .wrData (pwdata),
    .rdData (prdata)
  );

endmodule

// File: rtl/apb_zero_mem_chk.sv
module apb_zero_mem_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata
);

  localparam int BYTE_OFF = $clog2(DATA_W / 8);

  // Independent tracking of the last committed write
  logic              sawWrSetup;
  logic              justWrote;
  logic [ADDR_W-1:0] lastAddr;
  logic [DATA_W-1:0] lastData;
  logic              inWin;
  logic              readSetup;

  assign inWin     = (paddr[ADDR_W-1:WIN_BITS] == '0);
  assign readSetup = psel && !penable && !pwrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sawWrSetup <= 1'b0;
      justWrote  <= 1'b0;
      lastAddr   <= '0;
      lastData   <= '0;
    end else begin
      sawWrSetup <= psel && !penable && pwrite;
      justWrote  <= sawWrSetup && psel && penable && inWin;
      if (sawWrSetup && psel && penable) begin
        lastAddr <= paddr;
        lastData <= pwdata;
      end
    end
  end

  // R7: prdata only moves on a read setup
  assert_hold_outside_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    !readSetup |=> $stable(prdata));

  // R5: out-of-window read yields zero
  assert_oow_read_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (readSetup && !inWin) |=> (prdata == '0));

  // R6: read right after a write to the same word sees the new data
  assert_read_after_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (justWrote && readSetup && inWin &&
     paddr[WIN_BITS-1:BYTE_OFF] == lastAddr[WIN_BITS-1:BYTE_OFF])
    |=> (prdata == lastData));

  // R4: prdata is zero while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_zero_R4: assert (prdata == '0);
    end
  end

endmodule

bind apb_zero_mem apb_zero_mem_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .WIN_BITS(WIN_BITS)
) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .psel   (psel),
  .penable(penable),
  .pwrite (pwrite),
  .paddr  (paddr),
  .pwdata (pwdata),
  .prdata (prdata)
);

// File: tb/apb_zero_mem_tb_top.sv
module apb_zero_mem_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [31:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  apb_zero_mem dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .psel   (psel),
    .penable(penable),
    .pwrite (pwrite),
    .paddr  (paddr),
    .pwdata (pwdata),
    .prdata (prdata)
  );

  // {isWrite, req number, address, data or expected read}
  localparam logic [68:0] VEC [NVEC] = '{
    {1'b1, 4'd1, 32'h0000_0000, 32'h1111_1111},  // R1 write word 0
    {1'b1, 4'd8, 32'h0000_0004, 32'h2222_2222},  // R8 write word 1
    {1'b1, 4'd1, 32'h0000_0FFC, 32'hDEAD_BEEF},  // R1 write top word
    {1'b0, 4'd2, 32'h0000_0000, 32'h1111_1111},  // R2 read back word 0
    {1'b0, 4'd8, 32'h0000_0004, 32'h2222_2222},  // R8 word 1 independent
    {1'b0, 4'd2, 32'h0000_0FFC, 32'hDEAD_BEEF},  // R2 top word
    {1'b0, 4'd3, 32'h0000_0008, 32'h0000_0000},  // R3 unwritten reads zero
    {1'b1, 4'd5, 32'h0000_1004, 32'h5555_5555},  // R5 out-of-window write
    {1'b0, 4'd5, 32'h0000_0004, 32'h2222_2222},  // R5 alias untouched
    {1'b0, 4'd5, 32'h0000_1004, 32'h0000_0000},  // R5 out-of-window read zero
    {1'b1, 4'd8, 32'h0000_0002, 32'h7777_7777},  // R8 bits 1:0 not decoded
    {1'b0, 4'd8, 32'h0000_0000, 32'h7777_7777},  // R8 same word as 0x002
    {1'b0, 4'd3, 32'h0000_0800, 32'h0000_0000}   // R3 another unwritten word
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Setup then access; read data sampled mid access cycle
  task automatic xfer(input logic wr, input logic [31:0] addr, input logic [31:0] data,
                      input bit idleAfter, output logic [31:0] rd);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = data;
    @(negedge clk);
    penable = 1'b1;
    rd = prdata;
    if (idleAfter) begin
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwdata = '0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check("R4 reset", prdata, 32'h0);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R4 prdata during reset", prdata, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      xfer(VEC[i][68], VEC[i][63:32], VEC[i][31:0], 1'b1, rd);
      if (!VEC[i][68]) begin
        check($sformatf("R%0d table entry %0d", VEC[i][67:64], i), rd, VEC[i][31:0]);
      end
    end

    // R6: write then read same word, no idle between
    xfer(1'b1, 32'h0000_0100, 32'hCAFE_0001, 1'b0, rd);
    xfer(1'b0, 32'h0000_0100, 32'h0, 1'b1, rd);
    check("R6 back-to-back read", rd, 32'hCAFE_0001);
    xfer(1'b1, 32'h0000_0100, 32'hCAFE_0002, 1'b0, rd);
    xfer(1'b0, 32'h0000_0100, 32'h0, 1'b1, rd);
    check("R6 overwrite back-to-back", rd, 32'hCAFE_0002);

    // R7: access cycle without a setup stores nothing
    @(negedge clk);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 32'h0000_0010; pwdata = 32'hBAD0_BAD0;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    // psel low with write data present
    pwrite = 1'b1; paddr = 32'h0000_0014; pwdata = 32'hBAD1_BAD1;
    @(negedge clk);
    xfer(1'b0, 32'h0000_0010, 32'h0, 1'b1, rd);
    check("R7 stray access not stored", rd, 32'h0);
    xfer(1'b0, 32'h0000_0014, 32'h0, 1'b1, rd);
    check("R7 deselected cycle not stored", rd, 32'h0);

    // R7: prdata holds across a write and idle cycles
    xfer(1'b0, 32'h0000_0FFC, 32'h0, 1'b1, held);
    check("R2 read before hold test", held, 32'hDEAD_BEEF);
    xfer(1'b1, 32'h0000_0020, 32'h1234_5678, 1'b1, rd);
    repeat (3) @(negedge clk);
    check("R7 prdata held", prdata, 32'hDEAD_BEEF);

    // R4: reset mid-run erases written words
    doReset();
    xfer(1'b0, 32'h0000_0FFC, 32'h0, 1'b1, rd);
    check("R4 word cleared by reset", rd, 32'h0);
    xfer(1'b0, 32'h0000_0100, 32'h0, 1'b1, rd);
    check("R4 second word cleared by reset", rd, 32'h0);

    // R1: write again after reset and read back
    xfer(1'b1, 32'h0000_0FFC, 32'h0BAD_F00D, 1'b1, rd);
    xfer(1'b0, 32'h0000_0FFC, 32'h0, 1'b1, rd);
    check("R1 write after reset", rd, 32'h0BAD_F00D);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule